// File: doc/BRIEF.md
# Sliding-Window Zero Probability Estimator

This block watches a long stream of hard-decided bits read back from a memory array and keeps a running count of how many zeros fell inside the most recent window of code blocks. The window is made of a fixed number of equal sub-windows. Each sub-window is a whole number of code blocks. When a sub-window closes, the block publishes a fresh window zero count and pulses a strobe. A downstream threshold calculator divides that count by the window size in bits to obtain the zero probability.

The count is maintained incrementally. The design keeps a circular buffer with one zero count per sub-window. The window total moves forward by adding the zeros of the sub-window that just closed and subtracting those of the sub-window that drops out. The window is never recounted as a whole.

Before any live data is available, the output carries a zero count that was computed analytically and loaded through a preload port. That value stays on the output until the window has been completely filled once.

Top module: `zp_window_estimator`

## Requirements
- R1: After reset, `zero_cnt` is 0 and `upd_stb` is 0.
- R2: While the window has not yet been filled once, a cycle with `preload_en` high sets `zero_cnt` to `preload_cnt` in the next cycle, without raising `upd_stb`.
- R3: A bit counts as a zero only when `bit_valid` is 1 and `bit_in` is 0. The value of `bit_in` has no effect in cycles where `bit_valid` is 0.
- R4: A sub-window closes on the BLOCKS_PER_SUB-th `block_end` pulse counted since the previous close. A valid bit presented in the same cycle as that pulse belongs to the sub-window that is closing.
- R5: Until NUM_SUBS sub-windows have closed, `upd_stb` stays 0, and `zero_cnt` changes only through preload.
- R6: Every close from the NUM_SUBS-th one onward drives `zero_cnt`, one cycle later, to the number of zeros in the last NUM_SUBS sub-windows (W = BITS_PER_BLOCK × BLOCKS_PER_SUB × NUM_SUBS bits). `upd_stb` is 1 in that cycle and only in that cycle.
- R7: Once the window has been filled, `preload_en` is ignored and `zero_cnt` keeps its value.
- R8: The window total never exceeds W, and no sub-window count exceeds the number of bits in a sub-window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_valid | input | 1 | `bit_in` carries a stream bit this cycle |
| bit_in | input | 1 | Hard-decided stream bit |
| block_end | input | 1 | Pulse marking the end of a code block |
| preload_en | input | 1 | Load the initial zero count |
| preload_cnt | input | TOT_W | Analytic initial zero count |
| zero_cnt | output | TOT_W | Current window zero count |
| upd_stb | output | 1 | One-cycle pulse when `zero_cnt` carries a live update |

## Verification
The bench goes after the seam where the window first fills. A design that opens one sub-window too early or too late strobes on the wrong close, and its total then covers the wrong number of bits. The bench places a valid bit in the same cycle as the closing `block_end`, so a design that credits that bit to the next sub-window is off by one zero. It drives random `bit_in` values during invalid cycles to catch a counter that ignores `bit_valid`. It also applies preload both before and after the window fills, which exposes a design that lets preload overwrite live data. Streams of all zeros, all ones and random bits make the subtraction of the oldest sub-window visible, so a ring pointer that evicts the wrong entry shows up as a wrong total.

// File: rtl/zp_pkg.sv
package zp_pkg;

    // Bits needed to hold the values 0..n inclusive.
    function automatic int unsigned cnt_width(input int unsigned n);
        return (n < 1) ? 1 : $clog2(n + 1);
    endfunction

    // Bits needed to index n entries.
    function automatic int unsigned idx_width(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

    typedef enum logic {
        PH_FILL = 1'b0,
        PH_LIVE = 1'b1
    } zp_phase_e;

endpackage

// File: rtl/zp_subwin_counter.sv
module zp_subwin_counter
    import zp_pkg::*;
#(
    parameter int unsigned BITS_PER_BLOCK = 63,
    parameter int unsigned BLOCKS_PER_SUB = 1000,
    localparam int unsigned SUB_BITS = BITS_PER_BLOCK * BLOCKS_PER_SUB,
    localparam int unsigned SUB_W    = cnt_width(SUB_BITS),
    localparam int unsigned BLK_W    = idx_width(BLOCKS_PER_SUB)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bit_valid,
    input  logic             bit_in,
    input  logic             block_end,
    output logic             sub_done,
    output logic [SUB_W-1:0] sub_zeros
);

    logic [SUB_W-1:0] zero_acc;
    logic [BLK_W-1:0] blk_cnt;
    logic             zero_now;
    logic             last_blk;

    assign zero_now  = bit_valid & ~bit_in;
    assign last_blk  = block_end && (blk_cnt == BLK_W'(BLOCKS_PER_SUB - 1));
    assign sub_done  = last_blk;
    assign sub_zeros = zero_acc + SUB_W'(zero_now);

    always_ff @(posedge clk) begin
        if (rst) begin
            zero_acc <= '0;
            blk_cnt  <= '0;
        end else if (last_blk) begin
            zero_acc <= '0;
            blk_cnt  <= '0;
        end else begin
            zero_acc <= sub_zeros;
            if (block_end) begin
                blk_cnt <= blk_cnt + BLK_W'(1);
            end
        end
    end

    AST_SUB_BOUND: assert property (@(posedge clk) disable iff (rst)
        sub_done |-> (sub_zeros <= SUB_W'(SUB_BITS))) else $error("sub-window count too large"); // R8

    AST_BLK_WRAP: assert property (@(posedge clk) disable iff (rst)
        sub_done |=> (blk_cnt == '0)) else $error("block counter did not wrap"); // R4

endmodule

// File: rtl/zp_ring_total.sv
module zp_ring_total
    import zp_pkg::*;
#(
    parameter int unsigned BITS_PER_BLOCK = 63,
    parameter int unsigned BLOCKS_PER_SUB = 1000,
    parameter int unsigned NUM_SUBS       = 10,
    localparam int unsigned SUB_BITS = BITS_PER_BLOCK * BLOCKS_PER_SUB,
    localparam int unsigned WIN_BITS = SUB_BITS * NUM_SUBS,
    localparam int unsigned SUB_W    = cnt_width(SUB_BITS),
    localparam int unsigned TOT_W    = cnt_width(WIN_BITS),
    localparam int unsigned PTR_W    = idx_width(NUM_SUBS),
    localparam int unsigned FILL_W   = cnt_width(NUM_SUBS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sub_done,
    input  logic [SUB_W-1:0] sub_zeros,
    output logic [TOT_W-1:0] next_total,
    output logic             win_ready,
    output logic             win_full
);

    logic [SUB_W-1:0]  ring [NUM_SUBS];
    logic [PTR_W-1:0]  wr_ptr;
    logic [FILL_W-1:0] fill_cnt;
    logic [TOT_W-1:0]  total;
    logic [SUB_W-1:0]  oldest;

    assign oldest     = ring[wr_ptr];
    assign next_total = total + TOT_W'(sub_zeros) - TOT_W'(oldest);
    assign win_full   = (fill_cnt == FILL_W'(NUM_SUBS));
    assign win_ready  = sub_done && (win_full || (fill_cnt == FILL_W'(NUM_SUBS - 1)));

    for (genvar g = 0; g < NUM_SUBS; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                ring[g] <= '0;
            end else if (sub_done && (wr_ptr == PTR_W'(g))) begin
                ring[g] <= sub_zeros;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr   <= '0;
            fill_cnt <= '0;
            total    <= '0;
        end else if (sub_done) begin
            total  <= next_total;
            wr_ptr <= (wr_ptr == PTR_W'(NUM_SUBS - 1)) ? '0 : wr_ptr + PTR_W'(1);
            if (!win_full) begin
                fill_cnt <= fill_cnt + FILL_W'(1);
            end
        end
    end

    AST_TOTAL_BOUND: assert property (@(posedge clk) disable iff (rst)
        total <= TOT_W'(WIN_BITS)) else $error("window total too large"); // R8

    AST_FILL_BOUND: assert property (@(posedge clk) disable iff (rst)
        fill_cnt <= FILL_W'(NUM_SUBS)) else $error("fill counter overran"); // R5

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !sub_done |=> $stable(total)) else $error("total moved without a close"); // R6

endmodule

// File: rtl/zp_window_estimator.sv
module zp_window_estimator
    import zp_pkg::*;
#(
    parameter int unsigned BITS_PER_BLOCK = 63,
    parameter int unsigned BLOCKS_PER_SUB = 1000,
    parameter int unsigned NUM_SUBS       = 10,
    localparam int unsigned SUB_BITS = BITS_PER_BLOCK * BLOCKS_PER_SUB,
    localparam int unsigned WIN_BITS = SUB_BITS * NUM_SUBS,
    localparam int unsigned SUB_W    = cnt_width(SUB_BITS),
    localparam int unsigned TOT_W    = cnt_width(WIN_BITS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bit_valid,
    input  logic             bit_in,
    input  logic             block_end,
    input  logic             preload_en,
    input  logic [TOT_W-1:0] preload_cnt,
    output logic [TOT_W-1:0] zero_cnt,
    output logic             upd_stb
);

    logic             sub_done;
    logic [SUB_W-1:0] sub_zeros;
    logic [TOT_W-1:0] next_total;
    logic             win_ready;
    logic             win_full;
    zp_phase_e        phase;

    zp_subwin_counter #(
        .BITS_PER_BLOCK (BITS_PER_BLOCK),
        .BLOCKS_PER_SUB (BLOCKS_PER_SUB)
    ) i_sub (
        .clk       (clk),
        .rst       (rst),
        .bit_valid (bit_valid),
        .bit_in    (bit_in),
        .block_end (block_end),
        .sub_done  (sub_done),
        .sub_zeros (sub_zeros)
    );

    zp_ring_total #(
        .BITS_PER_BLOCK (BITS_PER_BLOCK),
        .BLOCKS_PER_SUB (BLOCKS_PER_SUB),
        .NUM_SUBS       (NUM_SUBS)
    ) i_ring (
        .clk        (clk),
        .rst        (rst),
        .sub_done   (sub_done),
        .sub_zeros  (sub_zeros),
        .next_total (next_total),
        .win_ready  (win_ready),
        .win_full   (win_full)
    );

    assign phase = win_full ? PH_LIVE : PH_FILL;

    always_ff @(posedge clk) begin
        if (rst) begin
            zero_cnt <= '0;
            upd_stb  <= 1'b0;
        end else if (win_ready) begin
            zero_cnt <= next_total;
            upd_stb  <= 1'b1;
        end else begin
            upd_stb <= 1'b0;
            if (preload_en && (phase == PH_FILL)) begin
                zero_cnt <= preload_cnt;
            end
        end
    end

    AST_NO_EARLY_STB: assert property (@(posedge clk) disable iff (rst)
        upd_stb |-> win_full) else $error("strobe before window filled"); // R5

    AST_FILL_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!win_full && !preload_en && !sub_done) |=> $stable(zero_cnt)) else $error("output moved while filling"); // R5

    AST_PRELOAD_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (win_full && !sub_done) |=> ($stable(zero_cnt) && !upd_stb)) else $error("output moved between closes"); // R7

    AST_OUT_BOUND: assert property (@(posedge clk) disable iff (rst)
        upd_stb |-> (zero_cnt <= TOT_W'(WIN_BITS))) else $error("published count too large"); // R8

endmodule

// File: tb/test_zp_window_estimator.sv
module test_zp_window_estimator;

    localparam int unsigned BPB  = 4;
    localparam int unsigned BPS  = 4;
    localparam int unsigned NS   = 3;
    localparam int unsigned W    = BPB * BPS * NS;
    localparam int unsigned TW   = zp_pkg::cnt_width(W);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          bit_valid = 1'b0;
    logic          bit_in = 1'b0;
    logic          block_end = 1'b0;
    logic          preload_en = 1'b0;
    logic [TW-1:0] preload_cnt = '0;
    logic [TW-1:0] zero_cnt;
    logic          upd_stb;

    int tests  = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // behavioural reference
    bit q[$];
    int blk_seen = 0;
    int subs_closed = 0;
    int exp_cnt = 0;
    bit exp_stb = 1'b0;

    always #4 clk = ~clk;

    zp_window_estimator #(
        .BITS_PER_BLOCK (BPB),
        .BLOCKS_PER_SUB (BPS),
        .NUM_SUBS       (NS)
    ) i_zp_window_estimator (
        .clk         (clk),
        .rst         (rst),
        .bit_valid   (bit_valid),
        .bit_in      (bit_in),
        .block_end   (block_end),
        .preload_en  (preload_en),
        .preload_cnt (preload_cnt),
        .zero_cnt    (zero_cnt),
        .upd_stb     (upd_stb)
    );

    function automatic int count_zeros();
        int z = 0;
        foreach (q[i]) if (q[i] == 1'b0) z++;
        return z;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // One cycle: drive at negedge, update reference at posedge, compare at next negedge.
    task automatic step(input bit v, input bit b, input bit be, input bit pl, input int pv);
        int prev_closed;
        bit_valid   = v;
        bit_in      = b;
        block_end   = be;
        preload_en  = pl;
        preload_cnt = TW'(pv);
        @(posedge clk);
        prev_closed = subs_closed;
        exp_stb = 1'b0;
        if (v) begin
            q.push_back(b);
            if (q.size() > W) void'(q.pop_front());
        end
        if (be) begin
            blk_seen++;
            if (blk_seen == BPS) begin
                blk_seen = 0;
                subs_closed++;
                if (subs_closed >= NS) begin
                    exp_cnt = count_zeros();
                    exp_stb = 1'b1;
                end
            end
        end
        if (!exp_stb && pl && prev_closed < NS) exp_cnt = pv;
        @(negedge clk);
        // R3 R4 R6: count and strobe timing; R5 R2 R7 outside closes
        if (exp_stb) begin
            check("R6 count", int'(zero_cnt), exp_cnt);
            check("R6 strobe", int'(upd_stb), 1);
        end else begin
            check("R5 hold", int'(zero_cnt), exp_cnt);
            check("R5 strobe", int'(upd_stb), 0);
        end
    endtask

    // mode: 0 zeros, 1 ones, 2 alternating, 3 random; gaps inserts invalid cycles
    task automatic send_block(input int mode, input bit gaps);
        for (int i = 0; i < BPB; i++) begin
            bit b;
            case (mode)
                0: b = 1'b0;
                1: b = 1'b1;
                2: b = 1'(i % 2);
                default: b = 1'($urandom_range(0, 1));
            endcase
            if (gaps && ($urandom_range(0, 1) == 1)) begin
                step(1'b0, 1'($urandom_range(0, 1)), 1'b0, 1'b0, 0); // R3: ignored bit
            end
            step(1'b1, b, (i == BPB - 1), 1'b0, 0); // R4: last bit rides with block_end
        end
    endtask

    task automatic send_sub(input int mode, input bit gaps);
        for (int k = 0; k < BPS; k++) send_block(mode, gaps);
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 reset count", int'(zero_cnt), 0);
        check("R1 reset strobe", int'(upd_stb), 0);

        // R2: preload during fill
        step(1'b0, 1'b0, 1'b0, 1'b1, 17);
        check("R2 preload", int'(zero_cnt), 17);

        send_sub(0, 1'b0);
        send_sub(3, 1'b1);
        // R2: second preload still accepted before the window is full
        step(1'b0, 1'b1, 1'b0, 1'b1, 5);
        check("R2 preload again", int'(zero_cnt), 5);

        // third sub-window fills the window: first live update (R6)
        send_sub(2, 1'b0);

        // R7: preload ignored once full
        step(1'b0, 1'b0, 1'b0, 1'b1, 33);
        check("R7 preload ignored", int'(zero_cnt), exp_cnt);

        send_sub(1, 1'b1);
        send_sub(1, 1'b0);
        send_sub(0, 1'b1);
        send_sub(0, 1'b0);
        send_sub(0, 1'b0);
        check("R8 full-zero window", int'(zero_cnt), W);
        for (int r = 0; r < 12; r++) send_sub(3, 1'b1);
        step(1'b0, 1'b0, 1'b0, 1'b1, 1);
        check("R7 preload ignored late", int'(zero_cnt), exp_cnt);
        for (int r = 0; r < 6; r++) send_sub(r % 4, 1'b0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule